// File: doc/BRIEF.md
# Integer Add/Subtract Unit

This block is the combinational arithmetic core of a small soft processor's execute stage. It adds or reverse-subtracts two 32-bit operands (the second operand is B minus A, not A minus B), takes its carry-in either from a fixed constant or from the processor's carry flag, and tells the flag register whether the new carry should be stored. A separate compare mode computes B minus A and patches the top bit of the difference so that it acts as a less-than indicator.

The operation is chosen by three selector bits that match the low bits of the instruction's opcode. Register-operand and immediate-operand instructions therefore share one decode, and operand B carries either a register value or an immediate that has already been sign-extended. The register file, immediate extension and the flag register itself live outside the block. The unit only drives the next carry value and its write enable.

Top module: `int_addsub_unit`

## Requirements
- R1: With compare mode off and op_sel bit 0 clear, result equals op_a + op_b + cin, modulo 2^32.
- R2: With compare mode off and op_sel bit 0 set, result equals op_b + ~op_a + cin, modulo 2^32. This is a reverse subtract.
- R3: When op_sel bit 1 is clear, cin is a constant: 1 when op_sel bit 0 is set and 0 when it is clear. When op_sel bit 1 is set, cin equals carry_flag.
- R4: carry_out is bit 32 of the 33-bit sum of the two adder operands and cin. In compare mode the adder operands are op_b, ~op_a and 1.
- R5: With compare mode off, carry_wr_en is 1 when op_sel bit 2 is clear. It is 0 when op_sel bit 2 is set, which is the keep-carry variant.
- R6: With cmp_en set and cmp_unsigned clear (signed compare), bits 30..0 of result equal bits 30..0 of op_b - op_a. Bit 31 of result equals op_b[31] when op_a[31] and op_b[31] differ.
- R7: With cmp_en set and cmp_unsigned set (unsigned compare), bits 30..0 of result equal bits 30..0 of op_b - op_a. Bit 31 of result equals op_a[31] when op_a[31] and op_b[31] differ.
- R8: In compare mode, carry_wr_en is 0. In compare mode, op_sel and carry_flag have no effect on result or carry_out.
- R9: In either compare mode, when op_a[31] equals op_b[31], result equals op_b - op_a with no patching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (register value) |
| op_b | input | 32 | Second operand (register value or sign-extended immediate) |
| op_sel | input | 3 | Bit 0 selects reverse subtract, bit 1 takes cin from the carry flag, bit 2 keeps the carry flag |
| cmp_en | input | 1 | Selects compare mode |
| cmp_unsigned | input | 1 | In compare mode, selects the unsigned patch instead of the signed one |
| carry_flag | input | 1 | Current value of the processor carry flag |
| result | output | 32 | Sum, difference or patched compare value |
| carry_out | output | 1 | Carry from bit 31 of the adder |
| carry_wr_en | output | 1 | Requests that carry_out be written into the carry flag |

## Verification
The compare path and the flag-driven carry-in can be selected in the same cycle. The bench does this by driving compare mode together with op_sel bit 1 set and carry_flag at both values. Result and carry_out must then match the cin-equals-1 difference for both flag values, and carry_wr_en must stay low. The sign patch is also exercised in the same cycle as a borrow: operand pairs with differing sign bits are chosen so that the adder's carry-out and the replaced bit 31 are both judged against the bench's own model.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  // Bit positions inside the 3-bit operation selector; the decoder depends on them.
  localparam int unsigned OPB_SUB  = 0;
  localparam int unsigned OPB_FLAG = 1;
  localparam int unsigned OPB_KEEP = 2;
  localparam int unsigned OPSEL_W  = 3;

  typedef enum logic [1:0] {
    CMPK_OFF      = 2'd0,
    CMPK_SIGNED   = 2'd1,
    CMPK_UNSIGNED = 2'd2
  } cmp_kind_e;
endpackage

// File: rtl/addsub_opprep.sv
module addsub_opprep #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         use_flag,
  input  logic         carry_flag,
  output logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic         cin
);
  // Reverse subtract feeds b and ~a; add feeds a and b.
  always_comb begin
    x = sub ? b  : a;
    y = sub ? ~a : b;
  end

  always_comb begin
    if (use_flag) cin = carry_flag;
    else          cin = sub;
  end

  always_comb begin
    if (!use_flag) assert_const_cin_R3: assert (cin == sub);
    if (sub) assert_inverted_a_R2: assert ((y ^ a) == {W{1'b1}});
  end
endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int unsigned EXT_W = W + 1;

  function automatic logic [EXT_W-1:0] add_ext(input logic [W-1:0] p,
                                               input logic [W-1:0] q,
                                               input logic c);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, c};
  endfunction

  logic [EXT_W-1:0] full;
  always_comb full = add_ext(x, y, cin);
  assign sum  = full[W-1:0];
  assign cout = full[W];

  // Wrap-around view of the carry: with no carry-in, a carry means the sum fell below x.
  always_comb begin
    if (!cin) assert_carry_wrap_R4: assert (cout == (sum < x));
    else      assert_carry_wrap1_R4: assert (cout == (sum <= x));
  end
endmodule

// File: rtl/addsub_cmpfix.sv
module addsub_cmpfix #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] diff,
  input  logic         is_unsigned,
  output logic [W-1:0] patched
);
  logic sign_split;
  logic top_bit;

  always_comb begin
    sign_split = a[W-1] ^ b[W-1];
    top_bit    = sign_split ? (is_unsigned ? a[W-1] : b[W-1]) : diff[W-1];
    patched    = {top_bit, diff[W-2:0]};
  end

  always_comb begin
    if (sign_split && !is_unsigned) assert_signed_patch_R6: assert (patched[W-1] == b[W-1]);
    if (sign_split &&  is_unsigned) assert_unsigned_patch_R7: assert (patched[W-1] != b[W-1]);
    if (!sign_split) assert_no_patch_R9: assert (patched == diff);
  end
endmodule

// File: rtl/int_addsub_unit.sv
module int_addsub_unit
  import addsub_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]  op_a,
  input  logic [DATA_W-1:0]  op_b,
  input  logic [OPSEL_W-1:0] op_sel,
  input  logic               cmp_en,
  input  logic               cmp_unsigned,
  input  logic               carry_flag,
  output logic [DATA_W-1:0]  result,
  output logic               carry_out,
  output logic               carry_wr_en
);
  cmp_kind_e         cmp_kind;
  logic              do_sub;
  logic              take_flag;
  logic [DATA_W-1:0] adder_x;
  logic [DATA_W-1:0] adder_y;
  logic              adder_cin;
  logic [DATA_W-1:0] adder_sum;
  logic              adder_cout;
  logic [DATA_W-1:0] cmp_value;

  always_comb begin
    if (!cmp_en)          cmp_kind = CMPK_OFF;
    else if (cmp_unsigned) cmp_kind = CMPK_UNSIGNED;
    else                   cmp_kind = CMPK_SIGNED;
  end

  // Compare forces a plain reverse subtract with constant carry-in.
  always_comb begin
    do_sub    = (cmp_kind != CMPK_OFF) | op_sel[OPB_SUB];
    take_flag = (cmp_kind == CMPK_OFF) & op_sel[OPB_FLAG];
  end

  addsub_opprep #(.W(DATA_W)) u_prep (
    .a(op_a), .b(op_b), .sub(do_sub), .use_flag(take_flag),
    .carry_flag(carry_flag), .x(adder_x), .y(adder_y), .cin(adder_cin)
  );

  addsub_adder #(.W(DATA_W)) u_add (
    .x(adder_x), .y(adder_y), .cin(adder_cin), .sum(adder_sum), .cout(adder_cout)
  );

  addsub_cmpfix #(.W(DATA_W)) u_fix (
    .a(op_a), .b(op_b), .diff(adder_sum),
    .is_unsigned(cmp_kind == CMPK_UNSIGNED), .patched(cmp_value)
  );

  always_comb begin
    result      = (cmp_kind == CMPK_OFF) ? adder_sum : cmp_value;
    carry_out   = adder_cout;
    carry_wr_en = (cmp_kind == CMPK_OFF) & ~op_sel[OPB_KEEP];
  end

  always_comb begin
    if (cmp_en) assert_cmp_no_write_R8: assert (!carry_wr_en && adder_cin);
    if (!cmp_en && op_sel[OPB_KEEP]) assert_keep_flag_R5: assert (!carry_wr_en);
  end
endmodule

// File: tb/int_addsub_unit_bench.sv
module int_addsub_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [2:0]  op_sel = '0;
  logic        cmp_en = 1'b0;
  logic        cmp_unsigned = 1'b0;
  logic        carry_flag = 1'b0;
  logic [31:0] result;
  logic        carry_out;
  logic        carry_wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        co;
    logic        we;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  int_addsub_unit u_int_addsub_unit (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .cmp_en(cmp_en),
    .cmp_unsigned(cmp_unsigned), .carry_flag(carry_flag),
    .result(result), .carry_out(carry_out), .carry_wr_en(carry_wr_en)
  );

  // Independent model: arithmetic on 64-bit integers.
  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [2:0] s,
                       input logic ce, input logic cu, input logic cf, input string tag);
    longint unsigned av, bv, ci, tot;
    exp_t e;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = s; cmp_en = ce; cmp_unsigned = cu; carry_flag = cf;
    av = longint'(a); bv = longint'(b);
    if (ce) begin
      tot = bv + (64'hFFFF_FFFF - av) + 1;
      e.res = tot[31:0];
      if (a[31] != b[31]) e.res[31] = cu ? a[31] : b[31];
      e.we = 1'b0;
    end else begin
      ci = s[1] ? longint'(cf) : longint'(s[0]);
      if (s[0]) tot = bv + (64'hFFFF_FFFF - av) + ci;
      else      tot = av + bv + ci;
      e.res = tot[31:0];
      e.we = ~s[2];
    end
    e.co = (tot >= 64'h1_0000_0000);
    e.tag = tag;
    expq.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      if (expq.size() > 0) begin
        e = expq.pop_front();
        checks++;
        if (result !== e.res || carry_out !== e.co || carry_wr_en !== e.we) begin
          errors++;
          $display("FAIL %s: got res=%h co=%b we=%b exp res=%h co=%b we=%b",
                   e.tag, result, carry_out, carry_wr_en, e.res, e.co, e.we);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] ra, rb;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Reset-state inputs all zero: plain add writing carry.
    drive(32'h0, 32'h0, 3'b000, 0, 0, 0, "R1 reset-state add");
    drive(32'h1234_5678, 32'h1111_1111, 3'b000, 0, 0, 1, "R1 add ignores flag");
    drive(32'hFFFF_FFFF, 32'h1, 3'b000, 0, 0, 0, "R4 add wraps with carry");
    drive(32'h5, 32'h3, 3'b001, 0, 0, 0, "R2 rsub negative");
    drive(32'h0, 32'h0, 3'b001, 0, 0, 0, "R4 rsub zero carries");
    drive(32'h3, 32'h5, 3'b011, 0, 0, 0, "R3 rsub flag=0");
    drive(32'h3, 32'h5, 3'b011, 0, 0, 1, "R3 rsub flag=1");
    drive(32'hFFFF_FFFF, 32'h0, 3'b010, 0, 0, 1, "R3 add flag carry");
    drive(32'h10, 32'h20, 3'b100, 0, 0, 0, "R5 keep add");
    drive(32'h10, 32'h20, 3'b111, 0, 0, 1, "R5 keep rsub flag");
    drive(32'h0000_0001, 32'h8000_0000, 3'b000, 1, 0, 0, "R6 signed split");
    drive(32'h8000_0000, 32'h0000_0001, 3'b000, 1, 0, 0, "R6 signed split rev");
    drive(32'h0000_0001, 32'h8000_0000, 3'b000, 1, 1, 0, "R7 unsigned split");
    drive(32'hFFFF_FFFF, 32'h0000_0000, 3'b000, 1, 1, 0, "R7 unsigned split borrow");
    drive(32'h0000_0007, 32'h0000_0003, 3'b000, 1, 0, 0, "R9 same sign");
    drive(32'h8000_0003, 32'h8000_0007, 3'b000, 1, 1, 0, "R9 same sign neg");
    drive(32'h4, 32'h9, 3'b010, 1, 0, 0, "R8 cmp flag sel flag=0");
    drive(32'h4, 32'h9, 3'b110, 1, 0, 1, "R8 cmp flag sel flag=1");
    drive(32'h4, 32'h9, 3'b001, 1, 1, 1, "R8 cmp sub sel");
    for (int i = 0; i < 200; i++) begin
      ra = $urandom; rb = $urandom;
      drive(ra, rb, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R1 R2 R6 R7 mixed");
    end
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule